// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM with a 19-bit word address and an 8-bit data bus. The host hands over one word at a time, a read or a write, through a valid/ready port. The controller turns each request into the active-low chip-select, read-strobe and write-strobe sequence the RAM needs. It steers the shared data bus so that the controller and the RAM never drive it at the same time.

Every strobe phase is stretched to whole clock cycles. The lengths come from minimum times in nanoseconds and the clock period, which are all parameters, and each division is rounded up. Examples are address-to-data time, strobe width, data setup before the write ends, bus turn-off time and minimum cycle time. A write is bounded by the window in which chip select and write strobe are both low. It ends when both rise together, and the write data is held through that edge. After reset, no access is started until a parameterised power-up interval has passed.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, `req_ready` stays low and `mem_ce_n` stays high for ceil(T_PWRUP_NS/CLK_NS) rising edges. `req_ready` is high after exactly that many edges. A request offered during that interval is ignored and leaves the RAM contents unchanged.
- R2: A read holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for RD cycles, where RD = ceil(max(T_AA_NS, T_DOE_NS, T_RC_NS)/CLK_NS). Any other strobe combination never opens a read.
- R3: Read data is captured on the edge that ends the read window. It is returned on `rsp_rdata` with `rsp_rvalid` high, RD+1 cycles after the accepting edge, as seen by the host.
- R4: The write-strobe low pulse lasts PW cycles, where PW = max(ceil(T_PWE_NS/C), ceil(T_SD_NS/C), ceil(T_WC_NS/C)-HZ, ceil(T_SCE_NS/C)-HZ). `mem_ce_n` is low for at least T_SCE_NS before the write ends.
- R5: `mem_oe_n` is high for the whole of every write. The controller drives the data bus only while `mem_oe_n` is high and `mem_we_n` is low.
- R6: `mem_addr` does not change while `mem_ce_n` stays low, so it is stable across the whole write-strobe pulse.
- R7: Write data is driven for the whole write-strobe pulse, for at least T_SD_NS before the edge that ends the write. That edge raises `mem_ce_n` and `mem_we_n` together.
- R8: `mem_ce_n` is high in the cycle in which a request is accepted, so chip select returns high between any two accesses.
- R9: `req_ready` is high only when the controller is idle and power-up has ended. `rsp_rvalid` and `rsp_wdone` are single-cycle pulses.
- R10: `rsp_wdone` is seen HZ+PW+1 cycles after the accepting edge, where HZ = ceil(T_HZOE_NS/CLK_NS) is the number of cycles the write strobe is held off with the data drivers off.
- R11: While idle or in reset, all three strobes are high and the controller's data drivers are off.
- R12: From chip select falling to the end of a write, at least T_WC_NS elapse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_rvalid |
| rsp_rvalid | output | 1 | One-cycle read-return pulse |
| rsp_wdone | output | 1 | One-cycle write-complete pulse |
| mem_addr | output | ADDR_W | RAM address |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_dq | inout | DATA_W | Shared RAM data bus |

## Verification
The bench builds the controller with ADDR_W=6, a 5 ns clock period and a 1000 ns power-up interval. With these values RD=3, HZ=2 and PW=2, and power-up takes 200 cycles. Every rounding-up path is exercised, because no timing minimum is a multiple of the 5 ns period. The 64-word space can be written, read back and interleaved in full within a short run. A behavioural RAM model on the bus measures each strobe window in clock samples. It returns unknown data until the address-to-data time has passed, so a read sampled too early shows up as wrong data.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_WSETUP = 2'd2,
        ST_WPULSE = 2'd3
    } asram_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic drive;
    } asram_pins_t;

    // Whole cycles covering a minimum time, never below one.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Strobe levels belonging to each sequencer phase.
    function automatic asram_pins_t pins_for(input asram_state_e st);
        asram_pins_t p;
        p = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
        case (st)
            ST_READ:   begin p.ce_n = 1'b0; p.oe_n = 1'b0; end
            ST_WSETUP: begin p.ce_n = 1'b0; end
            ST_WPULSE: begin p.ce_n = 1'b0; p.we_n = 1'b0; p.drive = 1'b1; end
            default:   ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/asram_pwrup_gate.sv
module asram_pwrup_gate #(
    parameter int CYC = 25000
) (
    input  logic clk,
    input  logic rst,
    output logic pwr_ok
);
    localparam int CNT_W = $clog2(CYC + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CYC);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign pwr_ok = (cnt == LIMIT);
endmodule

// File: rtl/asram_phase_fsm.sv
module asram_phase_fsm
    import asram_pkg::*;
#(
    parameter int RD_CYC = 3,
    parameter int HZ_CYC = 2,
    parameter int PW_CYC = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         start_wr,
    output asram_state_e state,
    output logic         last_rd,
    output logic         last_wr
);
    localparam int MAXC  = imax(imax(RD_CYC, HZ_CYC), PW_CYC);
    localparam int CNT_W = $clog2(MAXC + 1);

    logic [CNT_W-1:0] cnt;
    logic             at_end;

    assign at_end  = (cnt == '0);
    assign last_rd = (state == ST_READ)   && at_end;
    assign last_wr = (state == ST_WPULSE) && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= start_wr ? ST_WSETUP : ST_READ;
                        cnt   <= start_wr ? CNT_W'(HZ_CYC - 1) : CNT_W'(RD_CYC - 1);
                    end
                end
                ST_WSETUP: begin
                    if (at_end) begin
                        state <= ST_WPULSE;
                        cnt   <= CNT_W'(PW_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_READ, ST_WPULSE: begin
                    if (at_end) begin
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/asram_xfer_regs.sv
module asram_xfer_regs #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              last_rd,
    input  logic              last_wr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              wdone
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata   <= '0;
            rvalid  <= 1'b0;
            wdone   <= 1'b0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (last_rd) begin
                rdata <= dq_in;
            end
            rvalid <= last_rd;
            wdone  <= last_wr;
        end
    end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int DATA_W     = 8,
    parameter int CLK_NS     = 4,
    parameter int T_AA_NS    = 12,
    parameter int T_DOE_NS   = 6,
    parameter int T_RC_NS    = 12,
    parameter int T_HZOE_NS  = 6,
    parameter int T_PWE_NS   = 8,
    parameter int T_SD_NS    = 6,
    parameter int T_SCE_NS   = 8,
    parameter int T_WC_NS    = 12,
    parameter int T_PWRUP_NS = 100000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_rvalid,
    output logic              rsp_wdone,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    inout  wire  [DATA_W-1:0] mem_dq
);
    localparam int RD_CYC  = ns_to_cyc(imax(imax(T_AA_NS, T_DOE_NS), T_RC_NS), CLK_NS);
    localparam int HZ_CYC  = ns_to_cyc(T_HZOE_NS, CLK_NS);
    localparam int PW_CYC  = imax(imax(ns_to_cyc(T_PWE_NS, CLK_NS), ns_to_cyc(T_SD_NS, CLK_NS)),
                                  imax(ns_to_cyc(T_WC_NS, CLK_NS) - HZ_CYC,
                                       ns_to_cyc(T_SCE_NS, CLK_NS) - HZ_CYC));
    localparam int PWR_CYC = ns_to_cyc(T_PWRUP_NS, CLK_NS);

    asram_state_e      state;
    asram_pins_t       pins;
    logic              pwr_ok;
    logic              accept;
    logic              last_rd;
    logic              last_wr;
    logic              drv_en;
    logic [DATA_W-1:0] wdata_q;

    assign req_ready = pwr_ok && (state == ST_IDLE);
    assign accept    = req_valid && req_ready;

    asram_pwrup_gate #(.CYC(PWR_CYC)) i_pwrup (
        .clk    (clk),
        .rst    (rst),
        .pwr_ok (pwr_ok)
    );

    asram_phase_fsm #(.RD_CYC(RD_CYC), .HZ_CYC(HZ_CYC), .PW_CYC(PW_CYC)) i_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .start_wr (req_write),
        .state    (state),
        .last_rd  (last_rd),
        .last_wr  (last_wr)
    );

    asram_xfer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_xfer (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .last_rd   (last_rd),
        .last_wr   (last_wr),
        .dq_in     (mem_dq),
        .addr_q    (mem_addr),
        .wdata_q   (wdata_q),
        .rdata     (rsp_rdata),
        .rvalid    (rsp_rvalid),
        .wdone     (rsp_wdone)
    );

    assign pins     = pins_for(state);
    assign mem_ce_n = pins.ce_n;
    assign mem_oe_n = pins.oe_n;
    assign mem_we_n = pins.we_n;
    assign drv_en   = pins.drive;
    assign mem_dq   = drv_en ? wdata_q : {DATA_W{1'bz}};
endmodule

// File: rtl/asram_chk.sv
module asram_chk #(
    parameter int PWR_CYC = 1,
    parameter int PW_CYC  = 1,
    parameter int ADDR_W  = 19
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_rvalid,
    input logic              rsp_wdone,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              drv_en
);
    logic [31:0] up_cnt;
    logic [15:0] we_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            up_cnt <= '0;
            we_low <= '0;
        end else begin
            if (up_cnt != 32'hFFFF_FFFF) up_cnt <= up_cnt + 1'b1;
            we_low <= mem_we_n ? 16'd0 : ((we_low == 16'hFFFF) ? we_low : we_low + 1'b1);
        end
    end

    a_r1_pwrup_hold: assert property (@(posedge clk) disable iff (rst)
        (up_cnt < 32'(PWR_CYC)) |-> (mem_ce_n && !req_ready));

    a_r2_read_strobes: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n));

    a_r3_rvalid_after_read: assert property (@(posedge clk) disable iff (rst)
        rsp_rvalid |-> $past(!mem_oe_n));

    a_r4_we_width: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_low >= 16'(PW_CYC)));

    a_r5_drive_oe_high: assert property (@(posedge clk) disable iff (rst)
        drv_en |-> (mem_oe_n && !mem_we_n));

    a_r6_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    a_r7_data_over_pulse: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> drv_en);

    a_r8_ce_gap: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |-> mem_ce_n);

    a_r9_rvalid_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_rvalid |=> !rsp_rvalid);

    a_r9_wdone_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_wdone |=> !rsp_wdone);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        mem_ce_n |-> (mem_oe_n && mem_we_n && !drv_en));
endmodule

bind asram_ctrl asram_chk #(
    .PWR_CYC (PWR_CYC),
    .PW_CYC  (PW_CYC),
    .ADDR_W  (ADDR_W)
) i_asram_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_rvalid (rsp_rvalid),
    .rsp_wdone  (rsp_wdone),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .drv_en     (drv_en)
);

// File: tb/test_asram_ctrl.sv
`timescale 1ns/1ps

module asram_tb_model #(
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 8,
    parameter int CLK_NS  = 5,
    parameter int PWR_CYC = 200
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    inout wire  [DATA_W-1:0] dq
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [WORDS];
    int n_chk = 0;
    int n_err = 0;

    logic              rd_ok = 1'b0;
    logic              prev_rd = 1'b0, prev_wr = 1'b0;
    logic [ADDR_W-1:0] prev_addr = '0, w_addr = '0;
    logic [DATA_W-1:0] prev_dq = '0, w_data = '0;
    int cyc = 0, rd_cnt = 0, wlen = 0, dstable = 0, ce_len = 0, ce_len_w = 0;
    bit seen_ce = 0, addr_moved = 0, oe_bad = 0, x_bad = 0;

    wire mdrv = !ce_n && !oe_n && we_n;
    assign dq = mdrv ? (rd_ok ? mem[addr] : {DATA_W{1'bx}}) : {DATA_W{1'bz}};

    initial begin
        for (int i = 0; i < WORDS; i++) mem[i] = DATA_W'(i) ^ DATA_W'(8'h3C);
    end

    task automatic mchk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s model: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            cyc = 0; rd_cnt = 0; rd_ok = 1'b0; prev_rd = 1'b0; prev_wr = 1'b0; ce_len = 0;
        end else begin
            automatic bit rd = !ce_n && !oe_n && we_n;
            automatic bit wr = !ce_n && !we_n;
            cyc++;
            if (!ce_n && !seen_ce) begin
                seen_ce = 1;
                mchk(cyc > PWR_CYC, "R1 first chip select cycle", cyc, PWR_CYC + 1);
            end
            ce_len = ce_n ? 0 : ce_len + 1;
            if (rd) rd_cnt = (prev_rd && addr == prev_addr) ? rd_cnt + 1 : 1;
            else    rd_cnt = 0;
            rd_ok = (rd_cnt * CLK_NS >= 12);
            if (wr) begin
                if (!prev_wr) begin
                    wlen = 1; dstable = 1; addr_moved = 0; oe_bad = 0; x_bad = 0;
                end else begin
                    wlen++;
                    dstable = (dq !== prev_dq) ? 1 : dstable + 1;
                    if (addr != prev_addr) addr_moved = 1;
                end
                if (!oe_n) oe_bad = 1;
                if ($isunknown(dq)) x_bad = 1;
                w_addr = addr; w_data = dq; ce_len_w = ce_len;
            end else if (prev_wr) begin
                mchk(wlen * CLK_NS >= 8, "R4 write pulse ns", wlen * CLK_NS, 8);
                mchk(ce_len_w * CLK_NS >= 8, "R4 chip select before write end ns", ce_len_w * CLK_NS, 8);
                mchk(!oe_bad, "R5 output enable during write", oe_bad, 0);
                mchk(!addr_moved, "R6 address moved in write", addr_moved, 0);
                mchk(dstable * CLK_NS >= 6 && !x_bad, "R7 data setup ns", dstable * CLK_NS, 6);
                mchk(ce_len_w * CLK_NS >= 12, "R12 write cycle ns", ce_len_w * CLK_NS, 12);
                mchk(ce_n && we_n, "R7 write ends with both strobes high", {ce_n, we_n}, 3);
                mem[w_addr] = w_data;
            end
            prev_rd = rd; prev_wr = wr; prev_addr = addr; prev_dq = dq;
        end
    end
endmodule

module test_asram_ctrl;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;
    localparam int CLK_NS = 5;
    localparam int PWRUP  = 1000;
    localparam int WORDS  = 1 << ADDR_W;

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction
    localparam int E_PWR = cdiv(PWRUP, CLK_NS);
    localparam int E_RD  = cdiv(12, CLK_NS);
    localparam int E_HZ  = cdiv(6, CLK_NS);
    localparam int E_PW  = (cdiv(12, CLK_NS) - E_HZ > cdiv(8, CLK_NS)) ? cdiv(12, CLK_NS) - E_HZ : cdiv(8, CLK_NS);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic req_ready, rsp_rvalid, rsp_wdone, mem_ce_n, mem_oe_n, mem_we_n;
    logic [DATA_W-1:0] rsp_rdata;
    logic [ADDR_W-1:0] mem_addr;
    wire  [DATA_W-1:0] mem_dq;

    int checks = 0;
    int errors = 0;
    logic [DATA_W-1:0] expd [WORDS];

    always #2.5 clk = ~clk;

    asram_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_NS(CLK_NS), .T_PWRUP_NS(PWRUP)) i_asram_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_rvalid(rsp_rvalid), .rsp_wdone(rsp_wdone),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq(mem_dq)
    );

    asram_tb_model #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_NS(CLK_NS), .PWR_CYC(E_PWR)) i_model (
        .clk(clk), .rst(rst), .addr(mem_addr), .ce_n(mem_ce_n), .oe_n(mem_oe_n),
        .we_n(mem_we_n), .dq(mem_dq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] pat(input int a, input int k);
        return DATA_W'(a * 37 + 5 + k * 91) ^ DATA_W'(8'hA5);
    endfunction

    // Called on a negedge; returns on the negedge after the response pulse.
    task automatic access(input bit wr, input int a, input logic [DATA_W-1:0] d,
                          output logic [DATA_W-1:0] rd);
        int g = 0;
        int lat;
        while (!req_ready && g < 100) begin @(negedge clk); g++; end
        chk(req_ready, "R9 ready when idle", req_ready, 1);
        req_write = wr; req_addr = ADDR_W'(a); req_wdata = d; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R9 ready low while busy", req_ready, 0);
        lat = 1;
        while (!(wr ? rsp_wdone : rsp_rvalid) && lat < 100) begin @(negedge clk); lat++; end
        rd = rsp_rdata;
        if (wr) chk(lat == E_HZ + E_PW + 1, "R10 write completion latency", lat, E_HZ + E_PW + 1);
        else    chk(lat == E_RD + 1, "R3 read return latency", lat, E_RD + 1);
        @(negedge clk);
        chk(!rsp_rvalid && !rsp_wdone, "R9 response is one cycle", {rsp_rvalid, rsp_wdone}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors",
                 checks + i_model.n_chk, errors + i_model.n_err);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] got;
        for (int i = 0; i < WORDS; i++) expd[i] = DATA_W'(i) ^ DATA_W'(8'h3C);

        repeat (4) @(negedge clk);
        // R11 reset state
        chk(!req_ready, "R1 ready low in reset", req_ready, 0);
        chk(mem_ce_n && mem_oe_n && mem_we_n, "R11 strobes high in reset",
            {mem_ce_n, mem_oe_n, mem_we_n}, 7);
        chk(mem_dq === {DATA_W{1'bz}}, "R11 bus released in reset", mem_dq, 0);

        rst = 1'b0;
        for (int i = 1; i <= E_PWR; i++) begin
            // R1: a write offered during power-up must be ignored
            if (i == 5) begin
                req_valid = 1'b1; req_write = 1'b1; req_addr = '0; req_wdata = 8'hEE;
            end
            if (i == 9) req_valid = 1'b0;
            @(negedge clk);
            if (i < E_PWR && !mem_ce_n)
                chk(0, "R1 chip select during power-up", i, E_PWR);
            if (i == E_PWR - 1) chk(!req_ready, "R1 ready before wait ends", req_ready, 0);
            if (i == E_PWR)     chk(req_ready, "R1 ready when wait ends", req_ready, 1);
        end
        chk(mem_ce_n && mem_oe_n && mem_we_n, "R11 idle strobes high", {mem_ce_n, mem_oe_n, mem_we_n}, 7);

        access(1'b0, 0, '0, got);
        chk(got == expd[0], "R1 ignored write left word 0", got, expd[0]);

        for (int a = 0; a < WORDS; a++) begin
            access(1'b1, a, pat(a, 0), got);
            expd[a] = pat(a, 0);
        end
        for (int a = WORDS - 1; a >= 0; a--) begin
            access(1'b0, a, '0, got);
            chk(got == expd[a], "R2 read after write sweep", got, expd[a]);
        end
        for (int a = 0; a < WORDS; a++) begin
            access(1'b1, a, ~pat(a, 1), got);
            expd[a] = ~pat(a, 1);
            access(1'b0, a ^ 1, '0, got);
            chk(got == expd[a ^ 1], "R8 interleaved read", got, expd[a ^ 1]);
        end
        for (int a = 0; a < WORDS; a++) begin
            access(1'b0, a, '0, got);
            chk(got == expd[a], "R3 final readback", got, expd[a]);
        end
        @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n && mem_dq === {DATA_W{1'bz}},
            "R11 idle after traffic", {mem_ce_n, mem_oe_n, mem_we_n}, 7);

        $display("Simulation finished: %0d checks, %0d errors",
                 checks + i_model.n_chk, errors + i_model.n_err);
        $finish;
    end
endmodule